// File: doc/BRIEF.md
# External Interrupt Request Capture

This block gathers external interrupt requests for a small processor core. One dedicated input is active low. Four port inputs are active high and can be switched in as extra request sources by a static configuration input. All pins pass through a two-flop synchronizer. Requests are then qualified by edge detection and, optionally, by level detection, and are held in a single request latch. A second static configuration input chooses between edge-only sensitivity and edge-plus-level sensitivity.

The processor reads and writes a one-byte status/control register. The register holds an enable bit, shows the request latch as a flag, and has a write-only clear bit. The interrupt output is raised while three conditions hold together: the latch is set, the enable bit is set, and the core's mask input is low. The core pulses an acknowledge during its vector fetch, and this pulse empties the latch. A request that arrives in that same cycle is kept.

Top module: `irqx_ctrl`

## Requirements
- R1: With `cfg_level` low, a falling edge on `ext_irq_n` sets the flag. The flag stays set after the pin returns high. If the flag is cleared while the pin is held low, it stays clear.
- R2: With `cfg_port_en` high, a rising edge on one `port_irq` bit sets the flag only when the other three port bits are low and `ext_irq_n` is high. A rising edge while another port bit is high sets nothing.
- R3: With `cfg_port_en` low, the `port_irq` inputs never set the flag and never raise `irq_out`, in either sensitivity mode.
- R4: With `cfg_level` high, a low level on `ext_irq_n` keeps setting the flag, and so does a high level on any enabled port bit. A clear issued while such a level is held leaves the flag set.
- R5: `irq_out` is high exactly when the flag is set, the enable bit is set and `cpu_mask` is low.
- R6: A `vec_ack` pulse clears the flag on the next clock edge. If a new request is qualified in the same cycle, the request wins and the flag stays set.
- R7: A write with bit 5 of `reg_wdata` at 1 clears the flag. A write with bit 5 at 0 leaves the flag unchanged. Every write loads bit 0 of `reg_wdata` into the enable bit.
- R8: `reg_rdata` shows the enable bit at bit 0 and the flag at bit 4. All other bits read 0, and this includes the clear bit at bit 5.
- R9: After a synchronous reset, the enable bit is 1, the flag is 0, `reg_rdata` is 8'h01 and `irq_out` is low.
- R10: A pin change that qualifies as a request shows up in the flag on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_irq | input | 4 | Port interrupt pins, active high, asynchronous |
| cfg_level | input | 1 | Static: 1 selects edge-plus-level sensitivity, 0 selects edge only |
| cfg_port_en | input | 1 | Static: 1 enables the port pins as request sources |
| cpu_mask | input | 1 | Core interrupt mask; 1 blocks `irq_out` |
| vec_ack | input | 1 | One-cycle pulse during the interrupt vector fetch |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
A stuck or lost request latch is visible at once in `reg_rdata` bit 4 and in `irq_out`, so the bench reads the flag after every stimulus. It checks the exact edge on which a request must land, three edges after the pin change, and one edge earlier when it must not yet be there. If the port qualification is wrong, for example a rising edge accepted while another port pin is high, the flag shows it within three cycles. A wrong priority between set and clear is seen on the edge right after a coincident acknowledge or clear write.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    parameter int IRQX_PORTS   = 4;
    parameter int IRQX_REG_W   = 8;

    // Register field positions (software-visible layout)
    localparam int EN_POS   = 0;
    localparam int FLAG_POS = 4;
    localparam int CLR_POS  = 5;

    localparam logic [IRQX_REG_W-1:0] READ_MASK =
        (IRQX_REG_W'(1) << EN_POS) | (IRQX_REG_W'(1) << FLAG_POS);

    // One synchronized sample of every interrupt pin
    typedef struct packed {
        logic                  ded_n;
        logic [IRQX_PORTS-1:0] port;
    } pin_sample_t;

    localparam int SAMPLE_W = $bits(pin_sample_t);

    // Idle pin levels: dedicated high, ports low
    localparam pin_sample_t PIN_IDLE = '{ded_n: 1'b1, port: '0};

    typedef enum logic [1:0] {
        LATCH_HOLD  = 2'd0,
        LATCH_SET   = 2'd1,
        LATCH_CLEAR = 2'd2
    } latch_op_t;

    // True when every port bit other than idx is low
    function automatic logic others_quiet(
        input logic [IRQX_PORTS-1:0] v,
        input int                    idx
    );
        logic [IRQX_PORTS-1:0] m;
        m = v;
        m[idx] = 1'b0;
        return (m == '0);
    endfunction

    // Set has priority over any clear source
    function automatic latch_op_t pick_op(input logic set, input logic clr);
        if (set)      return LATCH_SET;
        else if (clr) return LATCH_CLEAR;
        else          return LATCH_HOLD;
    endfunction

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync
    import irqx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t raw,
    output pin_sample_t cur,
    output pin_sample_t prev
);

    localparam int LAST = STAGES - 1;

    pin_sample_t chain [STAGES];
    pin_sample_t prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= PIN_IDLE;
                    else     chain[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= PIN_IDLE;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PIN_IDLE;
        else     prev_q <= chain[LAST];
    end

    assign cur  = chain[LAST];
    assign prev = prev_q;

endmodule

// File: rtl/irqx_detect.sv
module irqx_detect
    import irqx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pin_sample_t           cur,
    input  pin_sample_t           prev,
    input  logic                  cfg_level,
    input  logic                  cfg_port_en,
    output logic [IRQX_PORTS-1:0] port_edge,
    output logic                  set_req
);

    logic ded_fall;
    logic ded_level;
    logic port_level;

    assign ded_fall  = prev.ded_n & ~cur.ded_n;
    assign ded_level = ~cur.ded_n;

    generate
        for (genvar i = 0; i < IRQX_PORTS; i++) begin : g_port
            always_comb begin
                port_edge[i] = cfg_port_en
                             & cur.port[i] & ~prev.port[i]
                             & others_quiet(cur.port, i)
                             & cur.ded_n;
            end
        end
    endgenerate

    assign port_level = cfg_port_en & (|cur.port);

    always_comb begin
        set_req = ded_fall | (|port_edge);
        if (cfg_level) set_req = set_req | ded_level | port_level;
    end

    // R2
    port_edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_edge));

    // R3
    port_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_port_en |-> (port_edge == '0));

endmodule

// File: rtl/irqx_latch_regs.sv
module irqx_latch_regs
    import irqx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_req,
    input  logic                  vec_ack,
    input  logic                  reg_wr,
    input  logic [IRQX_REG_W-1:0] reg_wdata,
    output logic                  flag,
    output logic                  en,
    output logic [IRQX_REG_W-1:0] reg_rdata
);

    logic      wr_clear;
    latch_op_t op;
    logic      unused_wbits;

    assign wr_clear     = reg_wr & reg_wdata[CLR_POS];
    assign op           = pick_op(set_req, wr_clear | vec_ack);
    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            unique case (op)
                LATCH_SET:   flag <= 1'b1;
                LATCH_CLEAR: flag <= 1'b0;
                default:     flag <= flag;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         en <= 1'b1;
        else if (reg_wr) en <= reg_wdata[EN_POS];
    end

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[EN_POS]   = en;
        reg_rdata[FLAG_POS] = flag;
    end

    // R1
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !set_req) |=> !flag);

    // R7
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[CLR_POS] && !set_req) |=> !flag);

    // R7
    wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[CLR_POS] && !set_req && !vec_ack)
            |=> (flag == $past(flag)));

    // R8
    rd_unused_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~READ_MASK) == '0);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!flag && en));

endmodule

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
    import irqx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ext_irq_n,
    input  logic [IRQX_PORTS-1:0] port_irq,
    input  logic                  cfg_level,
    input  logic                  cfg_port_en,
    input  logic                  cpu_mask,
    input  logic                  vec_ack,
    input  logic                  reg_wr,
    input  logic [IRQX_REG_W-1:0] reg_wdata,
    output logic [IRQX_REG_W-1:0] reg_rdata,
    output logic                  irq_out
);

    pin_sample_t           raw_pins;
    pin_sample_t           cur_pins;
    pin_sample_t           prev_pins;
    logic [IRQX_PORTS-1:0] port_edge;
    logic                  set_req;
    logic                  flag;
    logic                  en;

    assign raw_pins.ded_n = ext_irq_n;
    assign raw_pins.port  = port_irq;

    irqx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_pins),
        .cur  (cur_pins),
        .prev (prev_pins)
    );

    irqx_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .cur         (cur_pins),
        .prev        (prev_pins),
        .cfg_level   (cfg_level),
        .cfg_port_en (cfg_port_en),
        .port_edge   (port_edge),
        .set_req     (set_req)
    );

    irqx_latch_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_req),
        .vec_ack   (vec_ack),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flag      (flag),
        .en        (en),
        .reg_rdata (reg_rdata)
    );

    assign irq_out = flag & en & ~cpu_mask;

    // R5
    irq_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_mask || !reg_rdata[EN_POS]) |-> !irq_out);

endmodule

// File: tb/irqx_ctrl_test.sv
module irqx_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_irq_n = 1'b1;
    logic [3:0] port_irq = 4'b0;
    logic       cfg_level = 1'b0;
    logic       cfg_port_en = 1'b0;
    logic       cpu_mask = 1'b0;
    logic       vec_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int checks = 0;
    int misses = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqx_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .ext_irq_n   (ext_irq_n),
        .port_irq    (port_irq),
        .cfg_level   (cfg_level),
        .cfg_port_en (cfg_port_en),
        .cpu_mask    (cpu_mask),
        .vec_ack     (vec_ack),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_out     (irq_out)
    );

    // n rising edges, then settle on the falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    // flag is bit 4 of the register
    function automatic logic [7:0] flg();
        return {7'b0, reg_rdata[4]};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R9", "reset rdata", reg_rdata, 8'h01);
        chk("R9", "reset irq_out", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic t_dedicated_edge();
        cfg_level = 1'b0;
        ext_irq_n = 1'b0;
        step(2);
        chk("R10", "flag after two edges", flg(), 8'h00);
        step(1);
        chk("R10", "flag after three edges", flg(), 8'h01);
        chk("R5", "irq_out raised", {7'b0, irq_out}, 8'h01);
        chk("R8", "rdata with flag", reg_rdata, 8'h11);
        wr(8'h21);
        chk("R7", "clear write", flg(), 8'h00);
        step(3);
        chk("R1", "held low does not re-set", flg(), 8'h00);
        ext_irq_n = 1'b1;
        step(3);
        chk("R1", "rising edge does not set", flg(), 8'h00);
    endtask

    task automatic t_register();
        ext_irq_n = 1'b0;
        step(3);
        ext_irq_n = 1'b1;
        step(3);
        chk("R1", "flag stays after release", flg(), 8'h01);
        wr(8'h01);
        chk("R7", "write 0 to clear bit keeps flag", flg(), 8'h01);
        wr(8'h00);
        chk("R7", "enable cleared", reg_rdata, 8'h10);
        chk("R5", "irq_out low when disabled", {7'b0, irq_out}, 8'h00);
        wr(8'h01);
        chk("R5", "irq_out back with enable", {7'b0, irq_out}, 8'h01);
        cpu_mask = 1'b1;
        step(1);
        chk("R5", "irq_out masked", {7'b0, irq_out}, 8'h00);
        cpu_mask = 1'b0;
        step(1);
        chk("R5", "irq_out unmasked", {7'b0, irq_out}, 8'h01);
        wr(8'hff);
        chk("R8", "clear bit and unused read zero", reg_rdata, 8'h01);
    endtask

    task automatic t_port_edges();
        cfg_port_en = 1'b1;
        port_irq = 4'b0001;
        step(3);
        chk("R2", "lone port edge sets", flg(), 8'h01);
        wr(8'h21);
        port_irq = 4'b1001;
        step(4);
        chk("R2", "edge with other port high ignored", flg(), 8'h00);
        port_irq = 4'b0000;
        step(4);
        chk("R2", "falling port edges ignored", flg(), 8'h00);
        ext_irq_n = 1'b0;
        step(3);
        wr(8'h21);
        port_irq = 4'b0100;
        step(4);
        chk("R2", "edge with dedicated low ignored", flg(), 8'h00);
        port_irq = 4'b0000;
        ext_irq_n = 1'b1;
        step(4);
        wr(8'h21);
        port_irq = 4'b0100;
        step(3);
        chk("R2", "pin 2 edge sets", flg(), 8'h01);
        port_irq = 4'b0000;
        step(3);
        wr(8'h21);
        cfg_port_en = 1'b0;
    endtask

    task automatic t_port_disabled();
        cfg_port_en = 1'b0;
        port_irq = 4'b0010;
        step(4);
        chk("R3", "disabled port edge", flg(), 8'h00);
        cfg_level = 1'b1;
        step(3);
        chk("R3", "disabled port level", {7'b0, irq_out}, 8'h00);
        cfg_level = 1'b0;
        port_irq = 4'b0000;
        step(3);
    endtask

    task automatic t_level();
        cfg_level = 1'b1;
        ext_irq_n = 1'b0;
        step(3);
        chk("R4", "level sets", flg(), 8'h01);
        wr(8'h21);
        chk("R4", "held level survives clear", flg(), 8'h01);
        ext_irq_n = 1'b1;
        step(3);
        wr(8'h21);
        chk("R4", "clear after release", flg(), 8'h00);
        cfg_port_en = 1'b1;
        port_irq = 4'b0110;
        step(3);
        chk("R4", "port level sets", flg(), 8'h01);
        wr(8'h21);
        chk("R4", "port level survives clear", flg(), 8'h01);
        port_irq = 4'b0000;
        step(3);
        wr(8'h21);
        chk("R4", "port clear after release", flg(), 8'h00);
        cfg_port_en = 1'b0;
        cfg_level = 1'b0;
    endtask

    task automatic t_vec_ack();
        ext_irq_n = 1'b0;
        step(2);
        vec_ack = 1'b1;
        step(1);
        vec_ack = 1'b0;
        chk("R6", "request wins over ack", flg(), 8'h01);
        ext_irq_n = 1'b1;
        step(3);
        vec_ack = 1'b1;
        step(1);
        vec_ack = 1'b0;
        chk("R6", "ack clears flag", flg(), 8'h00);
        chk("R6", "irq_out drops", {7'b0, irq_out}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_dedicated_edge();
        t_register();
        t_port_edges();
        t_port_disabled();
        t_level();
        t_vec_ack();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
            $finish;
        end
    end

endmodule